// File: doc/BRIEF.md
# SDRAM Self-Refresh and Power-Down Sequencer

This controller-side block puts an SDRAM to sleep when the host asks and brings it back safely. A sleep request with every bank idle takes the device into self refresh. The block can first issue a burst of AUTO REFRESH commands, then drives the one-cycle self-refresh entry command and holds CKE low until the host wakes it. After CKE returns high, the block keeps the command bus quiet for the exit delay. When burst refresh was selected at entry, it then issues a second refresh burst before handing the bus back.

A power-down request only drops CKE. The device does no refreshing in that state, so a cycle counter limits how long it may stay there. If the host has not woken the device before the limit, the block raises CKE itself and pulses a forced-wake flag. While CKE is low the command pins carry a deselect. A busy flag stays high from the moment the block leaves idle until it returns there.

Top module: `sdram_sleep_seq`

## Requirements
- R1: During and just after reset, cke_o is high, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b1111 (deselect), busy_o is low and forced_wake_o is low.
- R2: A self-refresh request while banks_idle_i is low is ignored: cke_o stays high, the command stays deselect and busy_o stays low.
- R3: With burst mode off, a self-refresh request accepted in idle produces, in the next cycle, a single entry cycle with cke_o low and command 4'b0001. The following cycles show cke_o low with deselect.
- R4: In self refresh, cke_o stays low for as long as wake_i is low. A wake raises cke_o in the next cycle.
- R5: After cke_o rises out of self refresh, the command stays deselect for EXIT_CYC cycles with busy_o high. Without burst mode the block then returns to idle with busy_o low.
- R6: With burst mode on, BURST_CNT refresh commands (cke_o high, 4'b0001) are issued AR_GAP cycles apart, the first one in the cycle after the request. The entry command follows AR_GAP+1 cycles after the last refresh.
- R7: With burst mode on, BURST_CNT refresh commands AR_GAP apart start right at the end of the exit delay. busy_o falls AR_GAP+1 cycles after the last one.
- R8: Burst mode is sampled in the cycle the self-refresh request is accepted. Later changes of burst_mode_i do not alter that sleep sequence.
- R9: A power-down request in idle drives cke_o low with busy_o high in the next cycle. A wake raises cke_o in the next cycle, which starts a PDX_CYC-cycle exit with busy_o high, and the block then returns to idle.
- R10: cke_o stays low in power down for at most TREF_CYC-PD_MARGIN cycles. On a forced wake, forced_wake_o is high for exactly the first cke-high cycle. A host wake in the last allowed cycle is not counted as forced.
- R11: When a self-refresh and a power-down request arrive together with all banks idle, self refresh is taken.
- R12: A wake in idle has no effect on any output.
- R13: While cke_o is low, the command is deselect in every cycle except the self-refresh entry cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sr_req_i | input | 1 | Self-refresh request |
| pd_req_i | input | 1 | Power-down request |
| banks_idle_i | input | 1 | All banks precharged |
| wake_i | input | 1 | Host wake request |
| burst_mode_i | input | 1 | Burst refresh around self refresh |
| cke_o | output | 1 | Clock enable to SDRAM |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| busy_o | output | 1 | Sequence in progress |
| forced_wake_o | output | 1 | Power down ended by the limit counter |

## Verification
The assertions check four properties on every cycle:
- a self-refresh request is refused while the banks are busy;
- CKE holds low through self refresh until a wake arrives;
- no command appears inside the exit window, and the pins carry a deselect whenever CKE is low;
- the length of a power-down stay and the forced-wake pulse match the limit.

The exact placement of each refresh in the two bursts is shown only by the bench's sweeps, which cover both burst settings and several self-refresh and power-down lengths and compare every cycle against arithmetic. The same holds for the sampling of burst mode at acceptance, the priority between requests, and the return to idle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_BURST, ST_SR_ENTER, ST_SELF_REFRESH,
    ST_SR_EXIT_WAIT, ST_POST_BURST, ST_POWER_DOWN, ST_PD_EXIT
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_DESEL   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdram_cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
endpackage

// File: rtl/sleep_age_cnt.sv
// Cycles spent in the current state; cleared on a state change, saturating.
module sleep_age_cnt #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] MAX_VAL = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != MAX_VAL)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sleep_ar_burst.sv
// Issues BURST_CNT refresh strobes AR_GAP cycles apart, then a done pulse.
module sleep_ar_burst #(
  parameter int unsigned BURST_CNT = 4096,
  parameter int unsigned AR_GAP    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ar_o,
  output logic done_o
);
  localparam int unsigned RW = $clog2(BURST_CNT + 1);
  localparam int unsigned GW = $clog2(AR_GAP + 1);
  localparam logic [RW-1:0] REM_INIT = RW'(BURST_CNT);
  localparam logic [GW-1:0] GAP_LAST = GW'(AR_GAP - 1);

  logic          active_q;
  logic [RW-1:0] rem_q;
  logic [GW-1:0] gap_q;

  assign ar_o   = active_q && (gap_q == '0) && (rem_q != '0);
  assign done_o = active_q && (gap_q == '0) && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
      gap_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rem_q    <= REM_INIT;
      gap_q    <= '0;
    end else if (active_q) begin
      if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
        gap_q <= GAP_LAST;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  // R6/R7: a new burst never starts on top of one in progress
  assert_burst_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  assert_burst_done_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !ar_o && !done_o);
endmodule

// File: rtl/sdram_sleep_seq.sv
module sdram_sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned BURST_CNT = 4096,
  parameter int unsigned AR_GAP    = 8,
  parameter int unsigned EXIT_CYC  = 12,
  parameter int unsigned TREF_CYC  = 1280000,
  parameter int unsigned PD_MARGIN = 64,
  parameter int unsigned PDX_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_req_i,
  input  logic pd_req_i,
  input  logic banks_idle_i,
  input  logic wake_i,
  input  logic burst_mode_i,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic busy_o,
  output logic forced_wake_o
);
  localparam int unsigned PD_LIMIT = TREF_CYC - PD_MARGIN;
  localparam int unsigned AGE_MAX  = (PD_LIMIT > EXIT_CYC) ?
                                     ((PD_LIMIT > PDX_CYC) ? PD_LIMIT : PDX_CYC) :
                                     ((EXIT_CYC > PDX_CYC) ? EXIT_CYC : PDX_CYC);
  localparam int unsigned AGE_W    = $clog2(AGE_MAX + 2);
  localparam logic [AGE_W-1:0] EXIT_LAST = AGE_W'(EXIT_CYC - 1);
  localparam logic [AGE_W-1:0] PD_LAST   = AGE_W'(PD_LIMIT - 1);
  localparam logic [AGE_W-1:0] PDX_LAST  = AGE_W'(PDX_CYC - 1);

  seq_state_e     state_q, state_d;
  logic           burst_q;
  logic           forced_q, forced_d;
  logic [AGE_W-1:0] age;
  logic           burst_start, burst_ar, burst_done;
  sdram_cmd_t     cmd;

  sleep_age_cnt #(.WIDTH(AGE_W)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (age)
  );

  assign burst_start = (state_d != state_q) &&
                       (state_d == ST_PRE_BURST || state_d == ST_POST_BURST);

  sleep_ar_burst #(.BURST_CNT(BURST_CNT), .AR_GAP(AR_GAP)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (burst_start),
    .ar_o    (burst_ar),
    .done_o  (burst_done)
  );

  always_comb begin
    state_d  = state_q;
    forced_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_req_i && banks_idle_i)
          state_d = burst_mode_i ? ST_PRE_BURST : ST_SR_ENTER;
        else if (pd_req_i)
          state_d = ST_POWER_DOWN;
      end
      ST_PRE_BURST:    if (burst_done) state_d = ST_SR_ENTER;
      ST_SR_ENTER:     state_d = ST_SELF_REFRESH;
      ST_SELF_REFRESH: if (wake_i) state_d = ST_SR_EXIT_WAIT;
      ST_SR_EXIT_WAIT: if (age == EXIT_LAST) state_d = burst_q ? ST_POST_BURST : ST_IDLE;
      ST_POST_BURST:   if (burst_done) state_d = ST_IDLE;
      ST_POWER_DOWN: begin
        if (wake_i) begin
          state_d = ST_PD_EXIT;
        end else if (age == PD_LAST) begin
          state_d  = ST_PD_EXIT;
          forced_d = 1'b1;
        end
      end
      ST_PD_EXIT:      if (age == PDX_LAST) state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      burst_q  <= 1'b0;
      forced_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      forced_q <= forced_d;
      if (state_q == ST_IDLE) burst_q <= burst_mode_i;
    end
  end

  always_comb begin
    cmd = CMD_DESEL;
    if (state_q == ST_SR_ENTER || burst_ar) cmd = CMD_REFRESH;
  end

  assign cke_o         = !(state_q == ST_SR_ENTER || state_q == ST_SELF_REFRESH ||
                           state_q == ST_POWER_DOWN);
  assign cs_n_o        = cmd.cs_n;
  assign ras_n_o       = cmd.ras_n;
  assign cas_n_o       = cmd.cas_n;
  assign we_n_o        = cmd.we_n;
  assign busy_o        = (state_q != ST_IDLE);
  assign forced_wake_o = forced_q;

  // Observation counters for the checks below
  logic [AGE_W-1:0] quiet_q, lowrun_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q  <= AGE_W'(EXIT_CYC);
      lowrun_q <= '0;
    end else begin
      if (state_q == ST_SELF_REFRESH)       quiet_q <= '0;
      else if (quiet_q < AGE_W'(EXIT_CYC)) quiet_q <= quiet_q + 1'b1;
      if (cke_o)                            lowrun_q <= '0;
      else if (lowrun_q != '1)              lowrun_q <= lowrun_q + 1'b1;
    end
  end

  assert_sr_needs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && sr_req_i && !banks_idle_i) |=>
      (state_q != ST_PRE_BURST && state_q != ST_SR_ENTER));
  assert_sr_cke_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SELF_REFRESH && !wake_i) |=> !cke_o);
  assert_exit_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && !cs_n_o) |-> quiet_q >= AGE_W'(EXIT_CYC));
  assert_pd_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWER_DOWN) |-> lowrun_q < AGE_W'(PD_LIMIT));
  assert_forced_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_wake_o |-> (cke_o && $past(!cke_o)));
  assert_cke_low_desel_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> cs_n_o);
endmodule

// File: tb/sdram_sleep_seq_tb.sv
`timescale 1ns/100ps
module sdram_sleep_seq_tb;
  localparam int B    = 4;
  localparam int G    = 3;
  localparam int EX   = 5;
  localparam int TREF = 20;
  localparam int MARG = 4;
  localparam int PDX  = 2;
  localparam int LIM  = TREF - MARG;
  localparam logic [3:0] DESEL = 4'b1111;
  localparam logic [3:0] REF   = 4'b0001;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sr_req_i = 0, pd_req_i = 0, banks_idle_i = 0, wake_i = 0, burst_mode_i = 0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, forced_wake_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sdram_sleep_seq #(.BURST_CNT(B), .AR_GAP(G), .EXIT_CYC(EX), .TREF_CYC(TREF),
                    .PD_MARGIN(MARG), .PDX_CYC(PDX)) u_dut (
    .clk_i, .rst_ni, .sr_req_i, .pd_req_i, .banks_idle_i, .wake_i, .burst_mode_i,
    .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .busy_o, .forced_wake_o);

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic expect_out(string req, logic cke, logic [3:0] cmd, logic busy, logic fw);
    logic [6:0] act, exp;
    act = {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, forced_wake_o};
    exp = {cke, cmd, busy, fw};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // refresh burst: index i in 0..B*G, refresh when i%G==0 and i<B*G
  task automatic burst_phase(string req);
    for (int i = 0; i <= B * G; i++) begin
      if (i % G == 0 && i < B * G) expect_out(req, 1, REF, 1, 0);
      else                         expect_out(req, 1, DESEL, 1, 0);
      step();
    end
  endtask

  task automatic run_sr(bit burst, int hold);
    sr_req_i = 1; banks_idle_i = 1; burst_mode_i = burst;
    step();
    sr_req_i = 0;
    burst_mode_i = !burst;                       // R8: must not matter now
    if (burst) burst_phase("R6");
    expect_out("R3", 0, REF, 1, 0);              // entry cycle
    step();
    for (int h = 0; h < hold; h++) begin
      expect_out("R4", 0, DESEL, 1, 0);          // also R13
      if (h == hold - 1) wake_i = 1;
      step();
      wake_i = 0;
    end
    for (int e = 0; e < EX; e++) begin
      expect_out("R5", 1, DESEL, 1, 0);
      step();
    end
    if (burst) burst_phase("R7");
    expect_out(burst ? "R7" : "R8", 1, DESEL, 0, 0);
    burst_mode_i = 0;
  endtask

  task automatic run_pd(int k);
    bit woke;
    pd_req_i = 1;
    step();
    pd_req_i = 0;
    woke = 0;
    for (int c = 1; c <= LIM; c++) begin
      expect_out("R9", 0, DESEL, 1, 0);
      if (c == k) wake_i = 1;
      step();
      wake_i = 0;
      if (c == k) begin woke = 1; break; end
    end
    for (int x = 0; x < PDX; x++) begin
      expect_out("R10", 1, DESEL, 1, (x == 0) && !woke);
      step();
    end
    expect_out("R9", 1, DESEL, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    expect_out("R1", 1, DESEL, 0, 0);
    step();
    rst_ni = 1;
    @(negedge clk_i);
    expect_out("R1", 1, DESEL, 0, 0);

    // R2: request refused while banks busy
    sr_req_i = 1; banks_idle_i = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      expect_out("R2", 1, DESEL, 0, 0);
    end
    sr_req_i = 0;

    // R12: wake in idle is inert
    wake_i = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_out("R12", 1, DESEL, 0, 0);
    end
    wake_i = 0;
    step();

    // R3..R8: sweep burst mode and self-refresh length
    for (int b = 0; b < 2; b++)
      for (int h = 1; h <= 4; h++) begin
        run_sr(b[0], h);
        step();
      end

    // R9/R10: sweep wake point across and beyond the limit
    for (int k = 1; k <= LIM + 2; k++) begin
      run_pd(k);
      step();
    end

    // R11: simultaneous requests, self refresh wins
    sr_req_i = 1; pd_req_i = 1; banks_idle_i = 1; burst_mode_i = 0;
    step();
    sr_req_i = 0; pd_req_i = 0;
    expect_out("R11", 0, REF, 1, 0);
    step();
    wake_i = 1;
    step();
    wake_i = 0;
    repeat (EX) step();
    expect_out("R11", 1, DESEL, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule